// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block turns one ARINC 429 receive line into 32-bit words. An external comparator front end reports each sample as one of three digital levels: data one, data zero, or null. The block collects these levels in three 10-position sampling shift registers. From those registers it decides when a data bit has arrived and what its value is. It checks that each pulse is followed by a return to null, that bits are spaced correctly, and that a proper gap precedes each word.

A complete word of 32 valid bits is presented on `word_data` together with a single-cycle `word_valid` strobe. A word that breaks a timing rule is discarded and reported with a single-cycle `word_error` strobe.

The block runs from a 1 MHz clock. In high speed every clock is a sample. In low speed only every eighth clock is a sample, so the same sample-count windows apply at the slower rate.

Control is a three-state machine:
- `ST_GAP` waits for a valid inter-word gap. It is entered after reset, after every accepted word and after every rejected word.
- `ST_ARMED` waits for the first bit of a word. It is entered from `ST_GAP` when the gap counter reaches three.
- `ST_RECV` collects bits. It returns to `ST_GAP` on completion or on rejection.

Top module: `a429_word_rx`

## Requirements
- R1: Synchronous reset clears all sampling and control state and drives `word_valid`, `word_error` and `word_data` to zero. After reset the block sits in `ST_GAP`. A word that arrives before a gap has been counted produces no strobe.
- R2: In high speed a sample is taken on every clock. With `low_speed` = 1 a sample is taken on every eighth clock, so all sample-count rules scale by eight in clock terms. A word sent with low-speed timing while the block is in high speed is rejected.
- R3: A data bit is recognised once, on the sample where both of these hold:
  - the three newest positions of the null register are null and hold no data level;
  - positions 3 to 9 of the one register (or of the zero register) contain three consecutive samples of that level.
  The bit value is 1 for the one level and 0 for the zero level.
- R4: The first bit of a word starts reception. Every later bit must arrive 8 to 12 samples after the previous one, both limits included. A spacing of 7 or fewer, or of 13 or more, rejects the word with `word_error`.
- R5: Bits fill the word first-received-first: the first bit lands in `word_data[0]` and the 32nd in `word_data[31]`. After the 32nd bit, `word_data` is updated and `word_valid` is high for one clock.
- R6: In `ST_GAP` the null register is inspected every 10 samples. An inspection succeeds when all ten positions are null. Each success advances a gap counter, and a failure clears it. When the counter reaches 3 the block moves to `ST_ARMED`. Bits arriving while in `ST_GAP` are ignored and raise no strobe.
- R7: If 13 samples pass after a bit without another bit, a partial word is discarded with one `word_error` pulse.
- R8: During reception, a sample in which not exactly one of the three levels is present rejects the word with `word_error`.
- R9: `word_data` changes only in a cycle where `word_valid` is high. A rejected word leaves it unchanged. `word_valid` and `word_error` are never high together.
- R10: Each `word_valid` and `word_error` pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz sample clock |
| rst | input | 1 | synchronous reset, active high |
| low_speed | input | 1 | 1 selects low-speed sampling (one sample per eight clocks) |
| lvl_one | input | 1 | comparator reports the data-one level |
| lvl_zero | input | 1 | comparator reports the data-zero level |
| lvl_null | input | 1 | comparator reports the null level |
| word_data | output | 32 | last accepted word, first received bit in bit 0 |
| word_valid | output | 1 | one-clock strobe: a new word is on `word_data` |
| word_error | output | 1 | one-clock strobe: a malformed word was dropped |

## Verification
Some internal faults leave the machine stuck in `ST_GAP` or `ST_ARMED`, for example a gap counter that never reaches its target or a spacing counter that is off by one. These show up as a missing `word_valid` within one word time. They can also show up as a spurious `word_error` within 13 samples of the bit where the spacing goes wrong. A faulty shift order or bit-value decode appears as a wrong `word_data` pattern on the very next strobe. Sweeping every pulse-high/null split over periods 7 to 13 therefore exposes window-edge faults within a single word of the affected setting.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    typedef enum logic [1:0] {
        ST_GAP   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RECV  = 2'd2
    } rx_state_t;

    localparam int LVL_ONE  = 0;
    localparam int LVL_ZERO = 1;
    localparam int LVL_NULL = 2;
    localparam int NUM_LVL  = 3;

endpackage

// File: rtl/a429_rx_tick.sv
module a429_rx_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic low_speed,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = low_speed ? (cnt == LAST) : 1'b1;

endmodule

// File: rtl/a429_rx_sampler.sv
module a429_rx_sampler
    import a429_rx_pkg::*;
#(
    parameter int SR_LEN = 10,
    parameter int RUN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic lvl_one,
    input  logic lvl_zero,
    input  logic lvl_null,
    output logic step,
    output logic bit_evt,
    output logic bit_val,
    output logic gap_null,
    output logic bad_sample
);
    localparam int NPOS = SR_LEN - 2 * RUN + 1;

    logic [NUM_LVL-1:0][SR_LEN-1:0] sh;
    logic [NUM_LVL-1:0]             lvl_in;
    logic [NUM_LVL-1:0]             newest;
    logic [NPOS-1:0]                one_hit;
    logic [NPOS-1:0]                zero_hit;
    logic                           low_null;
    logic                           low_clear;
    logic                           cond;
    logic                           cond_prev;

    assign lvl_in = {lvl_null, lvl_zero, lvl_one};

    // newest sample enters at position 0, oldest sits at SR_LEN-1
    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (tick) begin
            for (int k = 0; k < NUM_LVL; k++)
                sh[k] <= {sh[k][SR_LEN-2:0], lvl_in[k]};
        end
    end

    // a run of RUN equal data samples anywhere in the upper part
    generate
        for (genvar p = 0; p < NPOS; p++) begin : g_hit
            assign one_hit[p]  = &sh[LVL_ONE][RUN+p +: RUN];
            assign zero_hit[p] = &sh[LVL_ZERO][RUN+p +: RUN];
        end
    endgenerate

    assign low_null  = &sh[LVL_NULL][RUN-1:0];
    assign low_clear = ~|sh[LVL_ONE][RUN-1:0] & ~|sh[LVL_ZERO][RUN-1:0];
    assign cond      = low_null & low_clear & ((|one_hit) | (|zero_hit));
    assign bit_val   = |one_hit;
    assign gap_null  = &sh[LVL_NULL];

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_new
        assign newest[k] = sh[k][0];
    end
    assign bad_sample = !$onehot(newest);

    always_ff @(posedge clk) begin
        if (rst) begin
            step      <= 1'b0;
            cond_prev <= 1'b0;
        end else begin
            step <= tick;
            if (step)
                cond_prev <= cond;
        end
    end

    assign bit_evt = step & cond & ~cond_prev;

endmodule

// File: rtl/a429_rx_ctrl.sv
module a429_rx_ctrl
    import a429_rx_pkg::*;
#(
    parameter int WORD_BITS    = 32,
    parameter int MIN_SPACE    = 8,
    parameter int MAX_SPACE    = 12,
    parameter int GAP_INTERVAL = 10,
    parameter int GAP_NEEDED   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic                 bit_evt,
    input  logic                 bit_val,
    input  logic                 gap_null,
    input  logic                 bad_sample,
    output rx_state_t            state,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_valid,
    output logic                 word_error
);
    localparam int SPC_W = $clog2(MAX_SPACE + 2);
    localparam int NB_W  = $clog2(WORD_BITS + 1);
    localparam int TM_W  = (GAP_INTERVAL > 1) ? $clog2(GAP_INTERVAL) : 1;
    localparam int GC_W  = $clog2(GAP_NEEDED + 1);

    rx_state_t            state_d;
    logic [SPC_W-1:0]     spc;
    logic [SPC_W-1:0]     spc_n;
    logic [NB_W-1:0]      nbits;
    logic [TM_W-1:0]      gap_tmr;
    logic [GC_W-1:0]      gap_cnt;
    logic [WORD_BITS-2:0] acc;
    logic                 gap_tick;
    logic                 abort;
    logic                 done;

    assign spc_n    = spc + 1'b1;
    assign gap_tick = step && (state == ST_GAP) && (gap_tmr == TM_W'(GAP_INTERVAL - 1));

    // next state and word outcome
    always_comb begin
        state_d = state;
        abort   = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_GAP: begin
                if (gap_tick && gap_null && gap_cnt == GC_W'(GAP_NEEDED - 1))
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (bit_evt)
                    state_d = ST_RECV;
            end
            ST_RECV: begin
                if (step) begin
                    if (bad_sample)
                        abort = 1'b1;
                    else if (bit_evt) begin
                        if (spc_n < SPC_W'(MIN_SPACE) || spc_n > SPC_W'(MAX_SPACE))
                            abort = 1'b1;
                        else if (nbits == NB_W'(WORD_BITS - 1))
                            done = 1'b1;
                    end else if (spc_n > SPC_W'(MAX_SPACE))
                        abort = 1'b1;
                end
                if (abort || done)
                    state_d = ST_GAP;
            end
            default: state_d = ST_GAP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_GAP;
        else
            state <= state_d;
    end

    // counters, assembly and output strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            spc        <= '0;
            nbits      <= '0;
            gap_tmr    <= '0;
            gap_cnt    <= '0;
            acc        <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
            word_error <= 1'b0;
        end else begin
            word_valid <= done;
            word_error <= abort;
            if (done)
                word_data <= {bit_val, acc};
            unique case (state)
                ST_GAP: begin
                    if (step) begin
                        if (gap_tick) begin
                            gap_tmr <= '0;
                            gap_cnt <= gap_null ? gap_cnt + 1'b1 : '0;
                        end else begin
                            gap_tmr <= gap_tmr + 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    if (bit_evt) begin
                        acc   <= {bit_val, acc[WORD_BITS-2:1]};
                        nbits <= NB_W'(1);
                        spc   <= '0;
                    end
                end
                ST_RECV: begin
                    if (bit_evt && !abort) begin
                        acc   <= {bit_val, acc[WORD_BITS-2:1]};
                        nbits <= nbits + 1'b1;
                        spc   <= '0;
                    end else if (step) begin
                        spc <= spc_n;
                    end
                end
                default: ;
            endcase
            if (state_d == ST_GAP && state != ST_GAP) begin
                gap_tmr <= '0;
                gap_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
    import a429_rx_pkg::*;
#(
    parameter int WORD_BITS    = 32,
    parameter int SR_LEN       = 10,
    parameter int RUN          = 3,
    parameter int MIN_SPACE    = 8,
    parameter int MAX_SPACE    = 12,
    parameter int GAP_INTERVAL = 10,
    parameter int GAP_NEEDED   = 3,
    parameter int LS_DIV       = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 low_speed,
    input  logic                 lvl_one,
    input  logic                 lvl_zero,
    input  logic                 lvl_null,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_valid,
    output logic                 word_error
);
    logic      tick;
    logic      step;
    logic      bit_evt;
    logic      bit_val;
    logic      gap_null;
    logic      bad_sample;
    rx_state_t state;

    a429_rx_tick #(.DIV(LS_DIV)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .low_speed (low_speed),
        .tick      (tick)
    );

    a429_rx_sampler #(.SR_LEN(SR_LEN), .RUN(RUN)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .lvl_one    (lvl_one),
        .lvl_zero   (lvl_zero),
        .lvl_null   (lvl_null),
        .step       (step),
        .bit_evt    (bit_evt),
        .bit_val    (bit_val),
        .gap_null   (gap_null),
        .bad_sample (bad_sample)
    );

    a429_rx_ctrl #(
        .WORD_BITS    (WORD_BITS),
        .MIN_SPACE    (MIN_SPACE),
        .MAX_SPACE    (MAX_SPACE),
        .GAP_INTERVAL (GAP_INTERVAL),
        .GAP_NEEDED   (GAP_NEEDED)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .bit_evt    (bit_evt),
        .bit_val    (bit_val),
        .gap_null   (gap_null),
        .bad_sample (bad_sample),
        .state      (state),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_error (word_error)
    );

endmodule

// File: rtl/a429_word_rx_chk.sv
module a429_word_rx_chk
    import a429_rx_pkg::*;
#(
    parameter int WORD_BITS = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 step,
    input rx_state_t            state,
    input logic [WORD_BITS-1:0] word_data,
    input logic                 word_valid,
    input logic                 word_error
);

    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    a_r10_error_pulse: assert property (@(posedge clk) disable iff (rst)
        word_error |=> !word_error);

    a_r9_no_both: assert property (@(posedge clk) disable iff (rst)
        !(word_valid && word_error));

    a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_data));

    a_r6_arm_on_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && $past(state) == ST_GAP) |-> $past(step));

endmodule

bind a429_word_rx a429_word_rx_chk #(.WORD_BITS(WORD_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .state      (state),
    .word_data  (word_data),
    .word_valid (word_valid),
    .word_error (word_error)
);

// File: tb/a429_word_rx_tb.sv
module a429_word_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        low_speed = 1'b0;
    logic        lvl_one = 1'b0;
    logic        lvl_zero = 1'b0;
    logic        lvl_null = 1'b1;
    logic [31:0] word_data;
    logic        word_valid;
    logic        word_error;

    always #10 clk = ~clk;

    a429_word_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .low_speed  (low_speed),
        .lvl_one    (lvl_one),
        .lvl_zero   (lvl_zero),
        .lvl_null   (lvl_null),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_error (word_error)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          v_cnt = 0;
    int          e_cnt = 0;
    int          wide = 0;
    logic [31:0] last_data = '0;
    logic        pv = 1'b0;
    logic        pe = 1'b0;
    bit          finished = 1'b0;

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (word_valid) begin
            v_cnt++;
            last_data = word_data;
        end
        if (word_error)
            e_cnt++;
        if ((word_valid && pv) || (word_error && pe))
            wide++;
        pv = word_valid;
        pe = word_error;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // kind: 0 one, 1 zero, 2 null, 3 no level
    task automatic samp(input int kind, input int n);
        for (int i = 0; i < n; i++) begin
            lvl_one  = (kind == 0);
            lvl_zero = (kind == 1);
            lvl_null = (kind == 2);
            repeat (low_speed ? 8 : 1) @(negedge clk);
        end
    endtask

    task automatic send_bit(input bit b, input int h, input int l);
        samp(b ? 0 : 1, h);
        samp(2, l);
    endtask

    task automatic send_bits(input logic [31:0] d, input int first, input int last,
                             input int h, input int l);
        for (int i = first; i <= last; i++)
            send_bit(d[i], h, l);
    endtask

    task automatic run_word(input logic [31:0] d, input int h, input int l,
                            input bit exp_ok, input string req);
        int v0, e0;
        v0 = v_cnt;
        e0 = e_cnt;
        samp(2, 50);
        send_bits(d, 0, 31, h, l);
        samp(2, 16);
        if (exp_ok) begin
            chk(v_cnt == v0 + 1 && e_cnt == e0, req, "accepted word count", v_cnt - v0, 1);
            chk(last_data == d, req, "word bits", last_data, d);
        end else begin
            chk(e_cnt == e0 + 1 && v_cnt == v0, req, "rejected word errors", e_cnt - e0, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] good;
        int v0, e0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(word_valid == 0 && word_error == 0, "R1", "strobes in reset", {word_valid, word_error}, 0);
        chk(word_data == 0, "R1", "data in reset", word_data, 0);
        rst = 1'b0;

        // R1: word straight after reset, no gap counted yet
        v0 = v_cnt; e0 = e_cnt;
        send_bits(32'h1234_5678, 0, 31, 5, 5);
        samp(2, 16);
        chk(v_cnt == v0 && e_cnt == e0, "R1", "word before gap", v_cnt + e_cnt - v0 - e0, 0);

        // R3: constant patterns
        run_word(32'h0000_0000, 5, 5, 1'b1, "R3");
        run_word(32'hFFFF_FFFF, 5, 5, 1'b1, "R3");
        run_word(32'h0000_0001, 5, 5, 1'b1, "R5");
        run_word(32'h8000_0000, 5, 5, 1'b1, "R5");

        // R4: sweep of bit period and pulse split
        for (int p = 7; p <= 13; p++) begin
            for (int h = 3; h <= p - 3; h++) begin
                d = 32'h9E37_79B9 * (p * 16 + h);
                run_word(d, h, p - h, (p >= 8 && p <= 12), "R4");
            end
        end
        good = last_data;

        // R6: gap too short after a good word, next word ignored
        v0 = v_cnt; e0 = e_cnt;
        samp(2, 50);
        send_bits(32'hCAFE_0F0F, 0, 31, 5, 5);
        samp(2, 15);
        send_bits(32'h0BAD_F00D, 0, 31, 5, 5);
        samp(2, 16);
        chk(v_cnt == v0 + 1 && e_cnt == e0, "R6", "short gap strobes", v_cnt - v0, 1);
        chk(last_data == 32'hCAFE_0F0F, "R6", "short gap data", last_data, 32'hCAFE_0F0F);
        good = last_data;

        // R7: partial word then gap
        v0 = v_cnt; e0 = e_cnt;
        samp(2, 50);
        send_bits(32'h5555_AAAA, 0, 19, 5, 5);
        samp(2, 30);
        chk(e_cnt == e0 + 1 && v_cnt == v0, "R7", "partial word errors", e_cnt - e0, 1);

        // R8: a sample with no level inside bit 10's null
        v0 = v_cnt; e0 = e_cnt;
        samp(2, 50);
        d = 32'h3C3C_A5A5;
        send_bits(d, 0, 9, 5, 5);
        samp(d[10] ? 0 : 1, 5);
        samp(2, 2);
        samp(3, 1);
        samp(2, 2);
        send_bits(d, 11, 31, 5, 5);
        samp(2, 16);
        chk(e_cnt == e0 + 1 && v_cnt == v0, "R8", "bad sample errors", e_cnt - e0, 1);

        // R9: rejected words left the data alone
        chk(word_data == good, "R9", "data after rejects", word_data, good);

        // R2: low speed sampling
        low_speed = 1'b1;
        run_word(32'hF0E1_D2C3, 5, 5, 1'b1, "R2");
        run_word(32'h1357_9BDF, 7, 7, 1'b0, "R2");
        low_speed = 1'b0;

        // R2: low-speed timing seen in high speed
        v0 = v_cnt; e0 = e_cnt;
        samp(2, 50);
        for (int i = 0; i < 32; i++) begin
            samp(i % 3 == 0 ? 0 : 1, 40);
            samp(2, 40);
        end
        samp(2, 16);
        chk(e_cnt > e0 && v_cnt == v0, "R2", "slow word in fast mode", e_cnt - e0, 1);
        run_word(32'h2468_ACE0, 6, 5, 1'b1, "R2");

        // R1: reset in the middle of a word
        samp(2, 50);
        send_bits(32'h7777_1111, 0, 9, 5, 5);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(word_data == 0 && !word_valid && !word_error, "R1", "outputs after mid reset", word_data, 0);
        rst = 1'b0;
        v0 = v_cnt; e0 = e_cnt;
        send_bits(32'h7777_1111, 10, 31, 5, 5);
        samp(2, 16);
        chk(v_cnt == v0 && e_cnt == e0, "R1", "strobes after mid reset", v_cnt + e_cnt - v0 - e0, 0);
        run_word(32'hDEAD_BEEF, 5, 5, 1'b1, "R1");

        // R10: strobe widths over the whole run
        chk(wide == 0, "R10", "multi-cycle strobes", wide, 0);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule